// File: doc/BRIEF.md
# PDM Receive Mode Register with Chunk Trigger

This block holds the 32-bit mode word of a four-channel PDM receive path. A simple register port writes the word and reads it back. A write-protect input blocks every write while it is high. The stored word is split into the fields that the rest of the receive path uses: the chunk size, the filter decimation code, the filter order, the audio ratio code and one enable per channel.

The block also counts received samples. A strobe marks each accepted sample word. When the number of samples since the last event reaches the programmed chunk size, the block sets a sticky chunk flag. The DMA engine uses this flag as its trigger, and a clear pulse removes it. The counter restarts from zero on each event, so the next event comes after another full chunk.

Top module: `pdm_mode_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x10300000. This gives `chunk_size`=1, `dec_code`=0, `filt_order`=3, `audio_code`=0, `ch_en`=0 and `chunk_flag`=0.
- R2: When `reg_wr` is high and `wr_lock` is low on a clock edge, the new field values appear on the outputs and on `reg_rdata` after that edge.
- R3: When `reg_wr` is high and `wr_lock` is high, the write is ignored. No field and no readback bit changes.
- R4: An accepted write whose chunk value (bits 31:28) is not 1, 2, 4 or 8 leaves `chunk_size` unchanged. The other fields of the same write still take effect.
- R5: Bits 19:18 and 15:4 of `reg_rdata` always read zero, whatever was written to them.
- R6: The field positions are fixed as follows. Chunk is bits 31:28. Decimation code is bits 27:24. Filter order is bits 23:20. Audio code is bits 17:16. `ch_en[i]` is bit i for i = 0 to 3.
- R7: `chunk_flag` becomes 1 on the edge that accepts the Nth sample since the last event, where N is `chunk_size`. On that same edge the sample count returns to zero.
- R8: `chunk_flag` stays 1 until a cycle with `flag_clr` high and no new event. If a clear and a new event fall in the same cycle, the flag stays 1.
- R9: If `chunk_size` is lowered to or below the number of samples already counted, the next accepted sample raises the flag.
- R10: A cycle with `samp_vld` low does not advance the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the mode word |
| reg_wdata | input | 32 | Write data |
| wr_lock | input | 1 | Write protect; while high, writes are ignored |
| reg_rdata | output | 32 | Readback of the mode word |
| samp_vld | input | 1 | One accepted receive sample this cycle |
| flag_clr | input | 1 | Clears the chunk flag |
| chunk_size | output | 4 | Programmed chunk size |
| dec_code | output | 4 | Filter decimation code |
| filt_order | output | 4 | Filter order |
| audio_code | output | 2 | Audio ratio code |
| ch_en | output | 4 | Per-channel enables |
| chunk_flag | output | 1 | Sticky chunk-reached flag |

## Verification
The hardest cases to reach are the ones where the chunk size changes underneath a count already in progress (R9), and where a flag clear lands in the same cycle as a new event (R8). The stimulus starts a count at the largest chunk size, lets several samples accumulate, and then programs a smaller chunk. It also times `flag_clr` so that it lands on the edge that completes a chunk. A reference model kept in the bench tracks count and flag on every cycle, so each sample cycle is checked against it.

// File: rtl/pdm_mode_pkg.sv
package pdm_mode_pkg;
  localparam int REG_W     = 32;
  localparam int CH_N      = 4;
  localparam int CHUNK_W   = 4;
  localparam int DEC_W     = 4;
  localparam int ORD_W     = 4;
  localparam int AUD_W     = 2;
  localparam int CHUNK_LSB = 28;
  localparam int DEC_LSB   = 24;
  localparam int ORD_LSB   = 20;
  localparam int AUD_LSB   = 16;
  localparam int EN_LSB    = 0;
  localparam int MAX_CHUNK = 8;
  localparam int CNT_W     = $clog2(MAX_CHUNK + 1);

  typedef struct packed {
    logic [CHUNK_W-1:0] chunk;
    logic [DEC_W-1:0]   dec;
    logic [ORD_W-1:0]   order;
    logic [AUD_W-1:0]   aud;
    logic [CH_N-1:0]    en;
  } mode_t;

  localparam mode_t MODE_RST = '{chunk: 4'd1, dec: 4'd0, order: 4'd3, aud: 2'd0, en: 4'd0};

  // Chunk sizes accepted by the write port: single powers of two up to MAX_CHUNK.
  function automatic logic chunk_legal(input logic [CHUNK_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0) && (int'(v) <= MAX_CHUNK);
  endfunction

  function automatic mode_t unpack_mode(input logic [REG_W-1:0] w);
    mode_t m;
    m.chunk = w[CHUNK_LSB +: CHUNK_W];
    m.dec   = w[DEC_LSB   +: DEC_W];
    m.order = w[ORD_LSB   +: ORD_W];
    m.aud   = w[AUD_LSB   +: AUD_W];
    m.en    = w[EN_LSB    +: CH_N];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] pack_mode(input mode_t m);
    logic [REG_W-1:0] w;
    w = '0;
    w[CHUNK_LSB +: CHUNK_W] = m.chunk;
    w[DEC_LSB   +: DEC_W]   = m.dec;
    w[ORD_LSB   +: ORD_W]   = m.order;
    w[AUD_LSB   +: AUD_W]   = m.aud;
    w[EN_LSB    +: CH_N]    = m.en;
    return w;
  endfunction

  // Event test: the incremented count has reached (or passed) the chunk size.
  function automatic logic chunk_reached(input logic [CNT_W-1:0] cnt_next,
                                         input logic [CHUNK_W-1:0] size);
    return {1'b0, cnt_next} >= {1'b0, size};
  endfunction
endpackage

// File: rtl/pdm_mode_store.sv
module pdm_mode_store
  import pdm_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             wr_lock,
  input  logic [REG_W-1:0] reg_wdata,
  output mode_t            mode_q,
  output logic             wr_accept,
  output logic             chunk_take
);
  mode_t req;

  always_comb begin
    req        = unpack_mode(reg_wdata);
    wr_accept  = reg_wr && !wr_lock;
    chunk_take = wr_accept && chunk_legal(req.chunk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (wr_accept) begin
      mode_q.dec   <= req.dec;
      mode_q.order <= req.order;
      mode_q.aud   <= req.aud;
      mode_q.en    <= req.en;
      if (chunk_take) mode_q.chunk <= req.chunk;
    end
  end

  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_lock) |=> $stable(mode_q))
    else $error("R3: locked write changed the mode word");

  p_chunk_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !chunk_take) |=> $stable(mode_q.chunk))
    else $error("R4: illegal chunk value was stored");

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (mode_q.en == $past(reg_wdata[EN_LSB +: CH_N])))
    else $error("R2: accepted write not stored");
endmodule

// File: rtl/pdm_chunk_count.sv
module pdm_chunk_count
  import pdm_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_vld,
  input  logic               flag_clr,
  input  logic [CHUNK_W-1:0] size,
  output logic               flag_q,
  output logic               raise_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next  = cnt_q + 1'b1;
    raise_evt = samp_vld && chunk_reached(cnt_next, size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (samp_vld) cnt_q <= raise_evt ? '0 : cnt_next;
      if (raise_evt)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  p_raise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> (flag_q && cnt_q == '0))
    else $error("R7: event did not set flag / restart count");

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q)
    else $error("R8: flag dropped without clear");

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !raise_evt) |=> !flag_q)
    else $error("R8: clear did not drop flag");

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |=> $stable(cnt_q))
    else $error("R10: count moved without a sample");

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_CHUNK)
    else $error("R9: count passed the largest chunk");
endmodule

// File: rtl/pdm_mode_ctrl.sv
module pdm_mode_ctrl
  import pdm_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        wr_lock,
  output logic [31:0] reg_rdata,
  input  logic        samp_vld,
  input  logic        flag_clr,
  output logic [3:0]  chunk_size,
  output logic [3:0]  dec_code,
  output logic [3:0]  filt_order,
  output logic [1:0]  audio_code,
  output logic [3:0]  ch_en,
  output logic        chunk_flag
);
  mode_t mode_q;
  logic  wr_accept;
  logic  chunk_take;
  logic  raise_evt;

  pdm_mode_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .wr_lock    (wr_lock),
    .reg_wdata  (reg_wdata),
    .mode_q     (mode_q),
    .wr_accept  (wr_accept),
    .chunk_take (chunk_take)
  );

  pdm_chunk_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_vld  (samp_vld),
    .flag_clr  (flag_clr),
    .size      (mode_q.chunk),
    .flag_q    (chunk_flag),
    .raise_evt (raise_evt)
  );

  always_comb begin
    reg_rdata  = pack_mode(mode_q);
    chunk_size = mode_q.chunk;
    dec_code   = mode_q.dec;
    filt_order = mode_q.order;
    audio_code = mode_q.aud;
    ch_en      = mode_q.en;
  end

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[19:18] == 2'b00) && (reg_rdata[15:4] == 12'h000))
    else $error("R5: reserved bits nonzero");
endmodule

// File: tb/tb_pdm_mode_ctrl.sv
module tb_pdm_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        wr_lock = 1'b0;
  logic [31:0] reg_rdata;
  logic        samp_vld = 1'b0;
  logic        flag_clr = 1'b0;
  logic [3:0]  chunk_size, dec_code, filt_order, ch_en;
  logic [1:0]  audio_code;
  logic        chunk_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state kept by the bench.
  logic [3:0] m_chunk = 4'd1, m_dec = 4'd0, m_ord = 4'd3, m_en = 4'd0;
  logic [1:0] m_aud = 2'd0;
  int         m_cnt = 0;
  logic       m_flag = 1'b0;

  always #5 clk = ~clk;

  pdm_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .wr_lock(wr_lock), .reg_rdata(reg_rdata), .samp_vld(samp_vld),
    .flag_clr(flag_clr), .chunk_size(chunk_size), .dec_code(dec_code),
    .filt_order(filt_order), .audio_code(audio_code), .ch_en(ch_en),
    .chunk_flag(chunk_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Readback expected from the field layout in R6, reserved bits zero per R5.
  function automatic logic [31:0] exp_word();
    return {m_chunk, m_dec, m_ord, 2'b00, m_aud, 12'h000, m_en};
  endfunction

  task automatic check_fields(input string req);
    chk(req, reg_rdata, exp_word());
    chk(req, {chunk_size, dec_code, filt_order, audio_code, ch_en},
        {m_chunk, m_dec, m_ord, m_aud, m_en});
  endtask

  task automatic do_write(input logic [31:0] d, input logic lock, input string req);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; wr_lock = lock;
    @(posedge clk); #1;
    reg_wr = 1'b0; wr_lock = 1'b0;
    if (!lock) begin
      m_dec = d[27:24]; m_ord = d[23:20]; m_aud = d[17:16]; m_en = d[3:0];
      if (d[31:28] == 4'd1 || d[31:28] == 4'd2 || d[31:28] == 4'd4 || d[31:28] == 4'd8)
        m_chunk = d[31:28];
    end
    check_fields(req);
  endtask

  task automatic step(input logic v, input logic clr, input string req);
    logic raise;
    @(negedge clk);
    samp_vld = v; flag_clr = clr;
    @(posedge clk); #1;
    samp_vld = 1'b0; flag_clr = 1'b0;
    raise = 1'b0;
    if (v) begin
      if (m_cnt + 1 >= int'(m_chunk)) begin raise = 1'b1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    if (raise) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    chk(req, {31'd0, chunk_flag}, {31'd0, m_flag});
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", reg_rdata, 32'h1030_0000);
    chk("R1", {31'd0, chunk_flag}, 32'd0);
    check_fields("R1");
    rst_n = 1'b1;

    // R2 R4 R5 R6: sweep every chunk code with varied other fields, reserved bits all ones
    for (int v = 0; v < 16; v++) begin
      logic [3:0] c;
      c = 4'(v);
      do_write({c, c ^ 4'h5, ~c, 2'b11, c[1:0], 12'hFFF, c ^ 4'hA},
               1'b0, (v == 1 || v == 2 || v == 4 || v == 8) ? "R2" : "R4");
      chk("R5", {20'd0, reg_rdata[19:18], reg_rdata[15:4]}, 32'd0);
    end
    // R6 single-bit walk through the whole word
    for (int b = 0; b < 32; b++) do_write(32'h4000_0000 | (32'd1 << b), 1'b0, "R6");

    // R3 locked writes ignored
    do_write(32'h2512_0005, 1'b0, "R2");
    for (int v = 0; v < 16; v++)
      do_write({4'(v), 4'(15 - v), 4'(v), 4'h3, 12'h0, 4'(v)}, 1'b1, "R3");

    // R7 R10: every legal chunk, gapped sample stream
    for (int k = 0; k < 4; k++) begin
      do_write({4'(1 << k), 28'h0530_000F}, 1'b0, "R2");
      step(1'b0, 1'b1, "R8");
      for (int i = 0; i < 3 * (1 << k) + 4; i++) begin
        step((i % 3) != 1, (i % 5) == 4, ((i % 3) == 1) ? "R10" : "R7");
      end
    end

    // R8 clear collides with event: flag must stay set
    do_write(32'h2030_0000, 1'b0, "R2");
    step(1'b0, 1'b1, "R8");
    while (m_cnt != 0) step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");
    chk("R8", {31'd0, chunk_flag}, 32'd1);
    step(1'b0, 1'b0, "R8");

    // R9 shrink chunk below the count already held
    do_write(32'h8030_0000, 1'b0, "R2");
    step(1'b0, 1'b1, "R8");
    while (m_cnt != 0) step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R7");
    do_write(32'h2030_0000, 1'b0, "R2");
    step(1'b1, 1'b0, "R9");
    chk("R9", {31'd0, chunk_flag}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule